// File: doc/BRIEF.md
# Packet Dump Capture Controller

This block captures packets that arrive from a ring into an external dump buffer and streams the captured blocks back out to a packet output port. Each incoming packet, from its start word to its end word, is one block. Every word is written to the buffer together with a last-word tag in the bit above the data. A read-back engine follows the write side. It reads committed blocks in order and hands them to an output gate, which forwards or drops each block as a whole.

Control is a small set of levels. The dump enable starts a new dump on its rising edge and stops all buffer traffic the moment it falls. The output enable admits packets only at packet boundaries, and it cuts a packet short, with an error-marked end word, when it falls mid-packet. The counter-keep level either lets the two statistics counters run or holds them at zero. A block-count setting defines how many blocks make up one dump. The done status reports that every block of the current dump has been read back.

Top module: `pkt_dump_ctrl`

## Requirements
- R1: After reset, all write, read and output strobes are low, `dump_done_o` is low, and both counters read zero.
- R2: While the dump enable is high, except in the cycle in which it rises, each ring packet that starts with `in_sop_i` is written one word per cycle to consecutive buffer addresses. The buffer word is `{in_eop_i, in_data_i}`, with the last-word tag at bit DATA_W. Once `nof_blocks_i` packets are captured, further packets are not written.
- R3: Clearing the dump enable blocks buffer writes and reads in that same cycle. A packet cut this way is not counted and is never read back.
- R4: A rising edge of the dump enable clears both counters, the done flag and all pointers, so that the next dump writes from address 0.
- R5: Committed blocks are read back in order from address 0, with a read latency of one cycle. A block whose first word returns while the output enable is high is emitted with `out_sop_o` on its first word and `out_eop_o` on its last word.
- R6: A block whose first word returns while the output enable is low is dropped entirely, even if the enable rises before the block ends. It still counts as read back.
- R7: If the output enable or the dump enable is low while a packet is open on the output, the next output cycle is a single word with valid, end and error set and zero data. The rest of that block is dropped.
- R8: In the cycle after the output enable was low, the output carries no normal data word.
- R9: With counter-keep high, `cap_cnt_o` and `rd_cnt_o` count captured and read-back blocks. With it low, both read zero from the next cycle on and stay at zero.
- R10: `dump_done_o` is high exactly when the dump enable is high, the cycle is not the rising cycle, `nof_blocks_i` is non-zero, and the read-back block count equals `nof_blocks_i`. It goes low in the same cycle in which the dump enable falls.
- R11: A packet that would need a buffer address beyond 2**ADDR_W-1 is abandoned and never read back, and capture stops for the rest of the dump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dump_en_i | input | 1 | Dump enable; a rising edge starts a new dump |
| out_en_i | input | 1 | Output enable |
| keep_cnt_i | input | 1 | 1 lets the counters run, 0 holds them at zero |
| nof_blocks_i | input | CNT_W | Number of blocks in one dump |
| in_valid_i | input | 1 | Ring word valid |
| in_sop_i | input | 1 | Ring packet first word |
| in_eop_i | input | 1 | Ring packet last word |
| in_data_i | input | DATA_W | Ring word data |
| buf_wr_en_o | output | 1 | Buffer write strobe |
| buf_wr_addr_o | output | ADDR_W | Buffer write address |
| buf_wr_data_o | output | DATA_W+1 | Buffer write word, last-word tag at bit DATA_W |
| buf_rd_en_o | output | 1 | Buffer read strobe |
| buf_rd_addr_o | output | ADDR_W | Buffer read address |
| buf_rd_data_i | input | DATA_W+1 | Buffer read word, valid one cycle after the strobe |
| out_valid_o | output | 1 | Output word valid |
| out_sop_o | output | 1 | Output packet first word |
| out_eop_o | output | 1 | Output packet last word |
| out_err_o | output | 1 | Output packet ended by a cut |
| out_data_o | output | DATA_W | Output word data |
| cap_cnt_o | output | CNT_W | Captured block counter |
| rd_cnt_o | output | CNT_W | Read-back block counter |
| dump_done_o | output | 1 | Current dump fully read back |

## Verification
The assertions check on every cycle that buffer traffic stops when the dump enable is low, and that output framing stays consistent: every first word opens a packet and every other word falls inside one. They also check that an error word always terminates a packet with zero data, that no normal word follows a low output enable, that counters are zero after a low counter-keep and after a rising dump enable, and that write addresses advance by one within a packet. Only the bench scenarios show the content and order of what is read back. They also show that a block admitted late stays dropped, where a cut packet ends, the point at which capture stops for the block count and for the buffer size, and when the done flag appears.

// File: rtl/pkt_dump_pkg.sv
package pkt_dump_pkg;
  typedef enum logic [1:0] {
    CAP_OFF  = 2'd0,
    CAP_SEEK = 2'd1,
    CAP_BODY = 2'd2,
    CAP_STOP = 2'd3
  } cap_state_e;
endpackage

// File: rtl/pkt_dump_capture.sv
module pkt_dump_capture
  import pkt_dump_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic [CNT_W-1:0]  nof_blocks_i,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W:0]   wr_data_o,
  output logic [ADDR_W:0]   commit_ptr_o,
  output logic              blk_done_o
);
  localparam int PTR_W = ADDR_W + 1;

  cap_state_e       state_q, state_d;
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, commit_q, commit_d;
  logic [CNT_W-1:0] blk_q, blk_d;
  logic             room;

  assign room         = ~wr_ptr_q[ADDR_W];
  assign wr_addr_o    = wr_ptr_q[ADDR_W-1:0];
  assign wr_data_o    = {in_eop_i, in_data_i};
  assign commit_ptr_o = commit_q;

  always_comb begin
    state_d    = state_q;
    wr_ptr_d   = wr_ptr_q;
    commit_d   = commit_q;
    blk_d      = blk_q;
    wr_en_o    = 1'b0;
    blk_done_o = 1'b0;
    if (clr_i) begin
      state_d  = CAP_SEEK;
      wr_ptr_d = '0;
      commit_d = '0;
      blk_d    = '0;
    end else if (!run_i) begin
      state_d  = CAP_OFF;
      wr_ptr_d = commit_q;  // drop partial packet
    end else begin
      case (state_q)
        CAP_SEEK: begin
          if (in_valid_i && in_sop_i && (blk_q < nof_blocks_i)) begin
            if (!room) begin
              state_d = CAP_STOP;
            end else begin
              wr_en_o  = 1'b1;
              wr_ptr_d = wr_ptr_q + PTR_W'(1);
              if (in_eop_i) begin
                commit_d   = wr_ptr_q + PTR_W'(1);
                blk_d      = blk_q + CNT_W'(1);
                blk_done_o = 1'b1;
              end else begin
                state_d = CAP_BODY;
              end
            end
          end
        end
        CAP_BODY: begin
          if (in_valid_i) begin
            if (!room) begin
              state_d  = CAP_STOP;
              wr_ptr_d = commit_q;
            end else begin
              wr_en_o  = 1'b1;
              wr_ptr_d = wr_ptr_q + PTR_W'(1);
              if (in_eop_i) begin
                commit_d   = wr_ptr_q + PTR_W'(1);
                blk_d      = blk_q + CNT_W'(1);
                blk_done_o = 1'b1;
                state_d    = CAP_SEEK;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= CAP_OFF;
      wr_ptr_q <= '0;
      commit_q <= '0;
      blk_q    <= '0;
    end else begin
      state_q  <= state_d;
      wr_ptr_q <= wr_ptr_d;
      commit_q <= commit_d;
      blk_q    <= blk_d;
    end
  end
endmodule

// File: rtl/pkt_dump_readback.sv
module pkt_dump_readback #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic [ADDR_W:0]   commit_ptr_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W:0]   rd_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_first_o,
  output logic              rsp_last_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              blk_done_o,
  output logic [CNT_W-1:0]  rd_blk_o
);
  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0] rd_ptr_q;
  logic             rsp_q, first_q;
  logic [CNT_W-1:0] blk_q;

  assign rd_en_o     = run_i && (rd_ptr_q < commit_ptr_i);
  assign rd_addr_o   = rd_ptr_q[ADDR_W-1:0];
  assign rsp_valid_o = rsp_q && run_i;
  assign rsp_first_o = first_q;
  assign rsp_last_o  = rd_data_i[DATA_W];
  assign rsp_data_o  = rd_data_i[DATA_W-1:0];
  assign blk_done_o  = rsp_valid_o && rsp_last_o;
  assign rd_blk_o    = blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      rsp_q    <= 1'b0;
      first_q  <= 1'b1;
      blk_q    <= '0;
    end else if (clr_i) begin
      rd_ptr_q <= '0;
      rsp_q    <= 1'b0;
      first_q  <= 1'b1;
      blk_q    <= '0;
    end else begin
      rsp_q <= rd_en_o;
      if (rd_en_o) rd_ptr_q <= rd_ptr_q + PTR_W'(1);
      if (rsp_valid_o) first_q <= rsp_last_o;
      if (blk_done_o) blk_q <= blk_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pkt_dump_out_gate.sv
module pkt_dump_out_gate #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              out_en_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_first_i,
  input  logic              rsp_last_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic              out_err_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic open_q, pass_ok, abort, take;

  assign pass_ok = out_en_i && run_i;
  assign abort   = open_q && !pass_ok;
  // admit only at a first word, or continue an open packet
  assign take    = pass_ok && rsp_valid_i && (rsp_first_i || open_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q      <= 1'b0;
      out_valid_o <= 1'b0;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
      out_err_o   <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= 1'b0;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
      out_err_o   <= 1'b0;
      out_data_o  <= '0;
      if (abort) begin
        open_q      <= 1'b0;
        out_valid_o <= 1'b1;
        out_eop_o   <= 1'b1;
        out_err_o   <= 1'b1;
      end else if (take) begin
        open_q      <= !rsp_last_i;
        out_valid_o <= 1'b1;
        out_sop_o   <= rsp_first_i;
        out_eop_o   <= rsp_last_i;
        out_data_o  <= rsp_data_i;
      end
    end
  end
endmodule

// File: rtl/pkt_dump_ctrl.sv
module pkt_dump_ctrl #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dump_en_i,
  input  logic              out_en_i,
  input  logic              keep_cnt_i,
  input  logic [CNT_W-1:0]  nof_blocks_i,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              buf_wr_en_o,
  output logic [ADDR_W-1:0] buf_wr_addr_o,
  output logic [DATA_W:0]   buf_wr_data_o,
  output logic              buf_rd_en_o,
  output logic [ADDR_W-1:0] buf_rd_addr_o,
  input  logic [DATA_W:0]   buf_rd_data_i,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic              out_err_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [CNT_W-1:0]  cap_cnt_o,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic              dump_done_o
);
  logic              en_q, rise, run;
  logic [ADDR_W:0]   commit_ptr;
  logic              cap_blk_done, rd_blk_done;
  logic              rsp_valid, rsp_first, rsp_last;
  logic [DATA_W-1:0] rsp_data;
  logic [CNT_W-1:0]  rd_blk;

  assign rise = dump_en_i && !en_q;
  assign run  = dump_en_i && en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= dump_en_i;
  end

  pkt_dump_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .clr_i       (rise),
    .nof_blocks_i(nof_blocks_i),
    .in_valid_i  (in_valid_i),
    .in_sop_i    (in_sop_i),
    .in_eop_i    (in_eop_i),
    .in_data_i   (in_data_i),
    .wr_en_o     (buf_wr_en_o),
    .wr_addr_o   (buf_wr_addr_o),
    .wr_data_o   (buf_wr_data_o),
    .commit_ptr_o(commit_ptr),
    .blk_done_o  (cap_blk_done)
  );

  pkt_dump_readback #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_readback (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .clr_i       (rise),
    .commit_ptr_i(commit_ptr),
    .rd_en_o     (buf_rd_en_o),
    .rd_addr_o   (buf_rd_addr_o),
    .rd_data_i   (buf_rd_data_i),
    .rsp_valid_o (rsp_valid),
    .rsp_first_o (rsp_first),
    .rsp_last_o  (rsp_last),
    .rsp_data_o  (rsp_data),
    .blk_done_o  (rd_blk_done),
    .rd_blk_o    (rd_blk)
  );

  pkt_dump_out_gate #(.DATA_W(DATA_W)) u_out_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .out_en_i   (out_en_i),
    .rsp_valid_i(rsp_valid),
    .rsp_first_i(rsp_first),
    .rsp_last_i (rsp_last),
    .rsp_data_i (rsp_data),
    .out_valid_o(out_valid_o),
    .out_sop_o  (out_sop_o),
    .out_eop_o  (out_eop_o),
    .out_err_o  (out_err_o),
    .out_data_o (out_data_o)
  );

  // statistics counters, separate from the progress counts used for control
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_cnt_o <= '0;
      rd_cnt_o  <= '0;
    end else if (rise || !keep_cnt_i) begin
      cap_cnt_o <= '0;
      rd_cnt_o  <= '0;
    end else begin
      if (cap_blk_done) cap_cnt_o <= cap_cnt_o + CNT_W'(1);
      if (rd_blk_done)  rd_cnt_o  <= rd_cnt_o + CNT_W'(1);
    end
  end

  assign dump_done_o = run && (nof_blocks_i != '0) && (rd_blk == nof_blocks_i);
endmodule

// File: rtl/pkt_dump_ctrl_chk.sv
module pkt_dump_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dump_en_i,
  input logic              out_en_i,
  input logic              keep_cnt_i,
  input logic              buf_wr_en_o,
  input logic [ADDR_W-1:0] buf_wr_addr_o,
  input logic [DATA_W:0]   buf_wr_data_o,
  input logic              buf_rd_en_o,
  input logic              out_valid_o,
  input logic              out_sop_o,
  input logic              out_eop_o,
  input logic              out_err_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic [CNT_W-1:0]  cap_cnt_o,
  input logic [CNT_W-1:0]  rd_cnt_o,
  input logic              dump_done_o
);
  logic in_pkt_q, en_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q  <= 1'b0;
      en_seen_q <= 1'b0;
    end else begin
      en_seen_q <= dump_en_i;
      if (out_valid_o) in_pkt_q <= !out_eop_o;
    end
  end

  p_no_access_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dump_en_i |-> (!buf_wr_en_o && !buf_rd_en_o));

  p_wr_addr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_wr_en_o && !buf_wr_data_o[DATA_W]) |=>
      (!buf_wr_en_o || buf_wr_addr_o == ADDR_W'($past(buf_wr_addr_o) + 1'b1)));

  p_sop_opens_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_sop_o) |-> !in_pkt_q);

  p_body_inside_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_sop_o) |-> in_pkt_q);

  p_err_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_err_o |-> (out_valid_o && out_eop_o && out_data_o == '0));

  p_out_cut_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |=> (!out_valid_o || out_err_o));

  p_cnt_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !keep_cnt_i |=> (cap_cnt_o == '0 && rd_cnt_o == '0));

  p_rise_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dump_en_i && !en_seen_q) |=> (cap_cnt_o == '0 && rd_cnt_o == '0));

  p_no_done_at_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dump_en_i && !en_seen_q) |-> !dump_done_o);
endmodule

bind pkt_dump_ctrl pkt_dump_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dump_en_i    (dump_en_i),
  .out_en_i     (out_en_i),
  .keep_cnt_i   (keep_cnt_i),
  .buf_wr_en_o  (buf_wr_en_o),
  .buf_wr_addr_o(buf_wr_addr_o),
  .buf_wr_data_o(buf_wr_data_o),
  .buf_rd_en_o  (buf_rd_en_o),
  .out_valid_o  (out_valid_o),
  .out_sop_o    (out_sop_o),
  .out_eop_o    (out_eop_o),
  .out_err_o    (out_err_o),
  .out_data_o   (out_data_o),
  .cap_cnt_o    (cap_cnt_o),
  .rd_cnt_o     (rd_cnt_o),
  .dump_done_o  (dump_done_o)
);

// File: tb/pkt_dump_ctrl_bench.sv
`timescale 1ns/1ps
module pkt_dump_ctrl_bench;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam int CNT_W  = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LOG_N  = 256;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic              dump_en = 0, out_en = 0, keep = 1;
  logic [CNT_W-1:0]  nof = '0;
  logic              in_valid = 0, in_sop = 0, in_eop = 0;
  logic [DATA_W-1:0] in_data = '0;
  logic              buf_wr_en_o, buf_rd_en_o;
  logic [ADDR_W-1:0] buf_wr_addr_o, buf_rd_addr_o;
  logic [DATA_W:0]   buf_wr_data_o;
  logic [DATA_W:0]   rd_data = '0;
  logic              out_valid_o, out_sop_o, out_eop_o, out_err_o, dump_done_o;
  logic [DATA_W-1:0] out_data_o;
  logic [CNT_W-1:0]  cap_cnt_o, rd_cnt_o;

  pkt_dump_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_pkt_dump_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .dump_en_i(dump_en), .out_en_i(out_en),
    .keep_cnt_i(keep), .nof_blocks_i(nof), .in_valid_i(in_valid), .in_sop_i(in_sop),
    .in_eop_i(in_eop), .in_data_i(in_data), .buf_wr_en_o(buf_wr_en_o),
    .buf_wr_addr_o(buf_wr_addr_o), .buf_wr_data_o(buf_wr_data_o),
    .buf_rd_en_o(buf_rd_en_o), .buf_rd_addr_o(buf_rd_addr_o), .buf_rd_data_i(rd_data),
    .out_valid_o(out_valid_o), .out_sop_o(out_sop_o), .out_eop_o(out_eop_o),
    .out_err_o(out_err_o), .out_data_o(out_data_o), .cap_cnt_o(cap_cnt_o),
    .rd_cnt_o(rd_cnt_o), .dump_done_o(dump_done_o)
  );

  // buffer model: registered read, one cycle latency
  logic [DATA_W:0] mem [DEPTH];
  always @(posedge clk) begin
    if (buf_wr_en_o) mem[buf_wr_addr_o] <= buf_wr_data_o;
    if (buf_rd_en_o) rd_data <= mem[buf_rd_addr_o];
  end

  // output log
  logic              lg_sop [LOG_N];
  logic              lg_eop [LOG_N];
  logic              lg_err [LOG_N];
  logic [DATA_W-1:0] lg_data [LOG_N];
  int lg_n = 0;
  always @(negedge clk) begin
    if (out_valid_o && lg_n < LOG_N) begin
      lg_sop[lg_n]  <= out_sop_o;
      lg_eop[lg_n]  <= out_eop_o;
      lg_err[lg_n]  <= out_err_o;
      lg_data[lg_n] <= out_data_o;
      lg_n <= lg_n + 1;
    end
  end

  int checks = 0, errors = 0;
  int wr_seen, wr_first;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic start_dump(input int blocks);
    nof = CNT_W'(blocks);
    dump_en = 1'b1;
    @(negedge clk);
  endtask

  // drives one ring packet from a negedge; cut >= 0 drops the dump enable at that word
  task automatic send(input int len, input logic [DATA_W-1:0] seed, input int cut);
    wr_seen = 0;
    wr_first = -1;
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = (i == len - 1);
      in_data  = seed + DATA_W'(i);
      if (i == cut) dump_en = 1'b0;
      #1;
      if (buf_wr_en_o) begin
        if (wr_seen == 0) wr_first = int'(buf_wr_addr_o);
        wr_seen++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
  endtask

  task automatic chk_pkt(input int at, input int len, input logic [DATA_W-1:0] seed, input string req);
    int bad = 0;
    for (int i = 0; i < len; i++) begin
      if (lg_sop[at+i] !== (i == 0) || lg_eop[at+i] !== (i == len - 1) ||
          lg_err[at+i] !== 1'b0 || lg_data[at+i] !== seed + DATA_W'(i)) bad++;
    end
    chk(bad == 0, req, "packet words mismatched", bad, 0);
  endtask

  task automatic t_reset();
    chk(!out_valid_o && !buf_wr_en_o && !buf_rd_en_o, "R1", "strobes in reset",
        int'({out_valid_o, buf_wr_en_o, buf_rd_en_o}), 0);
    chk(cap_cnt_o == 0 && rd_cnt_o == 0 && !dump_done_o, "R1", "counters/done in reset",
        int'(cap_cnt_o) + int'(rd_cnt_o) + int'(dump_done_o), 0);
  endtask

  task automatic t_basic();
    int base;
    keep = 1'b1;
    out_en = 1'b1;
    start_dump(3);
    base = lg_n;
    send(2, 16'h0100, -1);
    chk(wr_first == 0 && wr_seen == 2, "R2", "first packet write addr", wr_first, 0);
    send(1, 16'h0200, -1);
    send(3, 16'h0300, -1);
    idle(12);
    chk(lg_n - base == 6, "R5", "read-back word count", lg_n - base, 6);
    chk_pkt(base, 2, 16'h0100, "R5");
    chk_pkt(base + 2, 1, 16'h0200, "R5");
    chk_pkt(base + 3, 3, 16'h0300, "R5");
    chk(cap_cnt_o == 3 && rd_cnt_o == 3, "R9", "counters after three blocks",
        int'(cap_cnt_o) * 16 + int'(rd_cnt_o), 3 * 16 + 3);
    chk(dump_done_o == 1'b1, "R10", "done after full read-back", int'(dump_done_o), 1);
    send(2, 16'h0400, -1);
    idle(8);
    chk(wr_seen == 0, "R2", "writes after block count reached", wr_seen, 0);
    chk(cap_cnt_o == 3 && lg_n - base == 6, "R2", "capture stopped", int'(cap_cnt_o), 3);
    dump_en = 1'b0;
    #1;
    chk(dump_done_o == 1'b0, "R10", "done drops with dump enable", int'(dump_done_o), 0);
    @(negedge clk);
  endtask

  task automatic t_restart();
    int base;
    chk(cap_cnt_o == 3, "R4", "counter before restart", int'(cap_cnt_o), 3);
    start_dump(1);
    chk(cap_cnt_o == 0 && rd_cnt_o == 0 && !dump_done_o, "R4", "cleared by rising enable",
        int'(cap_cnt_o) + int'(rd_cnt_o) + int'(dump_done_o), 0);
    base = lg_n;
    send(2, 16'h0500, -1);
    chk(wr_first == 0, "R4", "new dump write start address", wr_first, 0);
    idle(8);
    chk_pkt(base, 2, 16'h0500, "R4");
    chk(dump_done_o == 1'b1, "R10", "done with one-block dump", int'(dump_done_o), 1);
    dump_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_gate();
    int base;
    out_en = 1'b0;
    start_dump(3);
    base = lg_n;
    send(3, 16'h0600, -1);
    idle(8);
    chk(lg_n == base, "R6", "words out while output disabled", lg_n - base, 0);
    chk(rd_cnt_o == 1, "R6", "dropped block still read", int'(rd_cnt_o), 1);
    send(4, 16'h0700, -1);
    while (!buf_rd_en_o) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    out_en = 1'b1;  // first word already decided
    idle(6);
    chk(lg_n == base, "R6", "late enable admitted mid-block", lg_n - base, 0);
    send(2, 16'h0800, -1);
    idle(8);
    chk(lg_n - base == 2, "R6", "next block forwarded", lg_n - base, 2);
    chk_pkt(base, 2, 16'h0800, "R6");
    chk(rd_cnt_o == 3, "R6", "read-back count", int'(rd_cnt_o), 3);
    dump_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_abort();
    int base;
    out_en = 1'b1;
    start_dump(4);
    base = lg_n;
    send(6, 16'h0900, -1);
    while (!(out_valid_o && out_sop_o)) @(negedge clk);
    out_en = 1'b0;
    @(negedge clk);
    chk(out_valid_o && out_eop_o && out_err_o && out_data_o == 0, "R7", "cut end word",
        int'({out_valid_o, out_eop_o, out_err_o}), 7);
    idle(8);
    chk(lg_n - base == 2, "R8", "words after output cut", lg_n - base, 2);
    chk(rd_cnt_o == 1, "R7", "cut block still read", int'(rd_cnt_o), 1);
    out_en = 1'b1;
    base = lg_n;
    send(6, 16'h0a00, -1);
    while (!(out_valid_o && out_sop_o)) @(negedge clk);
    dump_en = 1'b0;
    #1;
    chk(!buf_rd_en_o, "R3", "read strobe after dump enable cleared", int'(buf_rd_en_o), 0);
    @(negedge clk);
    chk(out_valid_o && out_eop_o && out_err_o, "R7", "cut end on dump disable",
        int'({out_valid_o, out_eop_o, out_err_o}), 7);
    idle(6);
    chk(lg_n - base == 2, "R7", "words after dump cut", lg_n - base, 2);
  endtask

  task automatic t_cut_capture();
    start_dump(4);
    send(6, 16'h0b00, 3);
    chk(wr_seen == 3, "R3", "writes before dump enable cleared", wr_seen, 3);
    idle(4);
    chk(cap_cnt_o == 0, "R3", "cut packet counted", int'(cap_cnt_o), 0);
  endtask

  task automatic t_keep();
    keep = 1'b1;
    out_en = 1'b1;
    start_dump(5);
    send(1, 16'h0c00, -1);
    idle(6);
    chk(cap_cnt_o == 1 && rd_cnt_o == 1, "R9", "counting with keep set",
        int'(cap_cnt_o) + int'(rd_cnt_o), 2);
    keep = 1'b0;
    @(negedge clk);
    chk(cap_cnt_o == 0 && rd_cnt_o == 0, "R9", "zero after keep cleared",
        int'(cap_cnt_o) + int'(rd_cnt_o), 0);
    send(1, 16'h0c10, -1);
    idle(6);
    chk(cap_cnt_o == 0 && rd_cnt_o == 0, "R9", "held at zero", int'(cap_cnt_o) + int'(rd_cnt_o), 0);
    keep = 1'b1;
    send(2, 16'h0c20, -1);
    idle(8);
    chk(cap_cnt_o == 1 && rd_cnt_o == 1, "R9", "resume from zero",
        int'(cap_cnt_o) + int'(rd_cnt_o), 2);
    dump_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_full();
    int base;
    out_en = 1'b1;
    start_dump(10);
    base = lg_n;
    send(30, 16'h1000, -1);
    send(30, 16'h2000, -1);
    send(30, 16'h3000, -1);
    chk(wr_seen == 4, "R11", "words written of overflowing packet", wr_seen, 4);
    idle(40);
    chk(cap_cnt_o == 2 && rd_cnt_o == 2, "R11", "blocks kept",
        int'(cap_cnt_o) * 16 + int'(rd_cnt_o), 2 * 16 + 2);
    chk(lg_n - base == 60, "R11", "words read back", lg_n - base, 60);
    chk_pkt(base, 30, 16'h1000, "R11");
    chk_pkt(base + 30, 30, 16'h2000, "R11");
    send(2, 16'h4000, -1);
    chk(wr_seen == 0, "R11", "capture after overflow", wr_seen, 0);
    chk(dump_done_o == 1'b0, "R10", "done below block count", int'(dump_done_o), 0);
    dump_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    idle(2);
    t_reset();
    t_basic();
    t_restart();
    t_gate();
    t_abort();
    t_cut_capture();
    t_keep();
    t_full();
    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end
endmodule